// File: doc/BRIEF.md
# Battery Pack Fault Protection Controller

This block sits between the analog comparators of a series lithium stack (up to ten cells by default) and the gate drivers of the pack's charge and discharge switches. Its inputs are comparator flags that are already digital. Each cell reports four flags: above overvoltage, below the charge-enable level, below undervoltage, and above the undervoltage-release level. The pack reports four more: discharge overcurrent, short circuit, pack-pin recovery and charger present. Each of the four faults has its own delay counter, clocked by a shared base tick. A fault takes effect only when its flag stays high for the programmed number of ticks without a break.

When a fault trips, the block latches it. Each latched fault is then released by its own rule. An undervoltage puts the pack into a sleep state, and only a charger can end it. After an overcurrent or a short-circuit trip, the block turns on a probe current so that it can sense when the load has been removed. If an undervoltage follows, the probe stays on when an overcurrent started it and is cut when a short circuit started it. All four outputs are registered.

Top module: `battery_protect`

## Requirements
- R1: Counting starts when the overvoltage flag of any cell goes high.
  - Each `tick` cycle during which the flag stays high counts once.
  - When the count has reached `ovDelay`, the next `tick` cycle in which the flag is still high trips the fault.
  - On a trip, `chgEn` drops at that clock edge. The flag therefore has to be high during `ovDelay`+1 tick cycles.
  - Cycles in which `tick` is low never count.
- R2: An overvoltage trip holds `chgEn` low until every bit of `cellCe` is high in the same cycle.
  - `chgEn` then returns high at the next edge.
  - If only some cells are below the charge-enable level, `chgEn` stays low.
- R3: An overvoltage trip on its own leaves `dsgEn` high.
- R4: An undervoltage trip follows the same delay rule as R1, using `uvDelay`. At the trip edge, `chgEn` and `dsgEn` go low and `sleepMode` goes high.
- R5: While `sleepMode` is high, nothing leaves sleep except `chargerDet` high. At the next edge, `sleepMode` drops and `chgEn` rises, provided no overvoltage trip is latched.
- R6: After a wake from sleep, `dsgEn` stays low until every bit of `cellUvRel` is high in a cycle that is not in sleep. `dsgEn` rises at the next edge.
- R7: The discharge overcurrent flag (delay `docDelay`) and the short-circuit flag (delay `scDelay`) each trip on their own, following the rule of R1. Either trip drives `dsgEn` low and leaves `chgEn` unchanged.
- R8: A latched overcurrent or short-circuit trip is released only by `packRecover` high. `dsgEn` returns at the next edge if no other discharge fault is held.
- R9: `testCurEn` is high while an overcurrent or short-circuit trip is latched. During an undervoltage condition (asleep, or awake with discharge still held off by R6) it stays high for an overcurrent trip and is low for a short-circuit trip alone.
- R10: If a fault flag drops before its trip, that fault's count restarts from zero. Only an unbroken run of high flags trips the fault.
- R11: After reset the outputs are `chgEn`=1, `dsgEn`=1, `sleepMode`=0 and `testCurEn`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Base time tick for the delay counters, one cycle wide |
| cellOv | input | N_CELLS | Per cell: above overvoltage threshold |
| cellCe | input | N_CELLS | Per cell: below charge-enable threshold |
| cellUv | input | N_CELLS | Per cell: below undervoltage threshold |
| cellUvRel | input | N_CELLS | Per cell: above undervoltage-release level |
| docFlag | input | 1 | Discharge overcurrent comparator |
| scFlag | input | 1 | Short-circuit comparator |
| packRecover | input | 1 | Pack pin has recovered (load removed) |
| chargerDet | input | 1 | Charger present |
| ovDelay | input | DLY_W | Overvoltage delay in ticks |
| uvDelay | input | DLY_W | Undervoltage delay in ticks |
| docDelay | input | DLY_W | Overcurrent delay in ticks |
| scDelay | input | DLY_W | Short-circuit delay in ticks |
| chgEn | output | 1 | Charge switch enable |
| dsgEn | output | 1 | Discharge switch enable |
| sleepMode | output | 1 | Low-power sleep state |
| testCurEn | output | 1 | Load-probe current enable |

## Verification
The bench breaks an overvoltage run one tick short of its trip and checks that the fault does not trip on the old count. A design that kept its count across the break would cut charging early.

It wakes the pack with cells still below the release level. A design that re-entered sleep on the undervoltage still present, or that enabled discharge on wake, would fail there.

It runs an undervoltage against a latched short circuit and, separately, against a latched overcurrent. This catches a probe-current rule applied to the wrong fault.

It also holds the fault flags high while `tick` is low, and leaves one cell above the charge-enable level. These cases catch a design that counts clock cycles instead of ticks, or that releases the overvoltage trip on a single cell.

// File: rtl/bpp_pkg.sv
package bpp_pkg;

  localparam int NUM_FAULTS = 4;

  // Index of each fault in the qualifier's counter array.
  typedef enum logic [1:0] {
    FLT_OV  = 2'd0,
    FLT_UV  = 2'd1,
    FLT_DOC = 2'd2,
    FLT_SC  = 2'd3
  } faultIdx_e;

  // Strobes from the qualifier datapath to the control.
  typedef struct packed {
    logic ovTrip;
    logic uvTrip;
    logic docTrip;
    logic scTrip;
    logic allCe;
    logic allUvRel;
  } faultStrobe_t;

endpackage

// File: rtl/bpp_qualify.sv
module bpp_qualify
  import bpp_pkg::*;
#(
  parameter int N_CELLS = 10,
  parameter int DLY_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic [N_CELLS-1:0] cellOv,
  input  logic [N_CELLS-1:0] cellCe,
  input  logic [N_CELLS-1:0] cellUv,
  input  logic [N_CELLS-1:0] cellUvRel,
  input  logic               docFlag,
  input  logic               scFlag,
  input  logic [DLY_W-1:0]   ovDelay,
  input  logic [DLY_W-1:0]   uvDelay,
  input  logic [DLY_W-1:0]   docDelay,
  input  logic [DLY_W-1:0]   scDelay,
  output faultStrobe_t       stb
);

  logic [NUM_FAULTS-1:0] rawFlag;
  logic [NUM_FAULTS-1:0] tripHit;
  logic [DLY_W-1:0]      limit [NUM_FAULTS];

  always_comb begin
    rawFlag          = '0;
    rawFlag[FLT_OV]  = |cellOv;
    rawFlag[FLT_UV]  = |cellUv;
    rawFlag[FLT_DOC] = docFlag;
    rawFlag[FLT_SC]  = scFlag;
    limit[FLT_OV]    = ovDelay;
    limit[FLT_UV]    = uvDelay;
    limit[FLT_DOC]   = docDelay;
    limit[FLT_SC]    = scDelay;
  end

  for (genvar gi = 0; gi < NUM_FAULTS; gi++) begin : g_delay
    logic [DLY_W-1:0] cnt;

    // Restart on any gap; count ticks up to the limit and hold there.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt <= '0;
      end else if (!rawFlag[gi]) begin
        cnt <= '0;
      end else if (tick && (cnt != limit[gi])) begin
        cnt <= cnt + 1'b1;
      end
    end

    assign tripHit[gi] = rawFlag[gi] & tick & (cnt == limit[gi]);

    // R10: a dropped flag leaves the count at zero
    a_r10_restart: assert property (@(posedge clk) disable iff (!rstN)
      !rawFlag[gi] |=> (cnt == '0));
  end

  assign stb.ovTrip   = tripHit[FLT_OV];
  assign stb.uvTrip   = tripHit[FLT_UV];
  assign stb.docTrip  = tripHit[FLT_DOC];
  assign stb.scTrip   = tripHit[FLT_SC];
  assign stb.allCe    = &cellCe;
  assign stb.allUvRel = &cellUvRel;

endmodule

// File: rtl/bpp_ctrl.sv
module bpp_ctrl
  import bpp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  faultStrobe_t stb,
  input  logic         packRecover,
  input  logic         chargerDet,
  output logic         chgEn,
  output logic         dsgEn,
  output logic         sleepMode,
  output logic         testCurEn
);

  logic ovLatch, uvLock, docLatch, scLatch;
  logic ovNext, uvLockNext, sleepNext, docNext, scNext;
  logic uvStart;

  // A fresh undervoltage only counts when none is already being held.
  assign uvStart = stb.uvTrip & ~uvLock;

  always_comb begin
    ovNext     = stb.ovTrip ? 1'b1 : (stb.allCe ? 1'b0 : ovLatch);
    sleepNext  = uvStart ? 1'b1 : ((sleepMode && chargerDet) ? 1'b0 : sleepMode);
    uvLockNext = uvStart ? 1'b1 : ((!sleepMode && stb.allUvRel) ? 1'b0 : uvLock);
    docNext    = stb.docTrip ? 1'b1 : (packRecover ? 1'b0 : docLatch);
    scNext     = stb.scTrip ? 1'b1 : (packRecover ? 1'b0 : scLatch);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovLatch   <= 1'b0;
      uvLock    <= 1'b0;
      docLatch  <= 1'b0;
      scLatch   <= 1'b0;
      sleepMode <= 1'b0;
      chgEn     <= 1'b1;
      dsgEn     <= 1'b1;
      testCurEn <= 1'b0;
    end else begin
      ovLatch   <= ovNext;
      uvLock    <= uvLockNext;
      docLatch  <= docNext;
      scLatch   <= scNext;
      sleepMode <= sleepNext;
      chgEn     <= ~ovNext & ~sleepNext;
      dsgEn     <= ~(uvLockNext | docNext | scNext);
      testCurEn <= docNext | (scNext & ~uvLockNext);
    end
  end

  // R2: overvoltage release needs every cell below charge-enable
  a_r2_ov_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovLatch) |-> $past(stb.allCe));

  // R4: sleep is entered only through a qualified undervoltage
  a_r4_sleep_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepMode) |-> $past(stb.uvTrip));

  // R4: both switches are off while asleep
  a_r4_sleep_off: assert property (@(posedge clk) disable iff (!rstN)
    sleepMode |-> (!chgEn && !dsgEn));

  // R5: only a charger ends sleep
  a_r5_wake: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepMode) |-> $past(chargerDet));

  // R6: discharge after an undervoltage hold needs all cells released
  a_r6_uv_release: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dsgEn) && $past(uvLock)) |-> $past(stb.allUvRel));

  // R8: an overcurrent trip is cleared only by pack recovery
  a_r8_doc_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(docLatch) |-> $past(packRecover));

  // R9: the probe current runs only with discharge off
  a_r9_probe_dsg_off: assert property (@(posedge clk) disable iff (!rstN)
    testCurEn |-> !dsgEn);

endmodule

// File: rtl/battery_protect.sv
module battery_protect
  import bpp_pkg::*;
#(
  parameter int N_CELLS = 10,
  parameter int DLY_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic [N_CELLS-1:0] cellOv,
  input  logic [N_CELLS-1:0] cellCe,
  input  logic [N_CELLS-1:0] cellUv,
  input  logic [N_CELLS-1:0] cellUvRel,
  input  logic               docFlag,
  input  logic               scFlag,
  input  logic               packRecover,
  input  logic               chargerDet,
  input  logic [DLY_W-1:0]   ovDelay,
  input  logic [DLY_W-1:0]   uvDelay,
  input  logic [DLY_W-1:0]   docDelay,
  input  logic [DLY_W-1:0]   scDelay,
  output logic               chgEn,
  output logic               dsgEn,
  output logic               sleepMode,
  output logic               testCurEn
);

  faultStrobe_t stb;

  bpp_qualify #(.N_CELLS(N_CELLS), .DLY_W(DLY_W)) u_qualify (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .cellOv    (cellOv),
    .cellCe    (cellCe),
    .cellUv    (cellUv),
    .cellUvRel (cellUvRel),
    .docFlag   (docFlag),
    .scFlag    (scFlag),
    .ovDelay   (ovDelay),
    .uvDelay   (uvDelay),
    .docDelay  (docDelay),
    .scDelay   (scDelay),
    .stb       (stb)
  );

  bpp_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .packRecover (packRecover),
    .chargerDet  (chargerDet),
    .chgEn       (chgEn),
    .dsgEn       (dsgEn),
    .sleepMode   (sleepMode),
    .testCurEn   (testCurEn)
  );

endmodule

// File: tb/battery_protect_bench.sv
`timescale 1ns/1ps
module battery_protect_bench;

  localparam int N  = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tick = 1'b0;
  logic [N-1:0]  cellOv = '0, cellCe = '1, cellUv = '0, cellUvRel = '1;
  logic          docFlag = 1'b0, scFlag = 1'b0, packRecover = 1'b0, chargerDet = 1'b0;
  logic [DW-1:0] ovDelay = 8'd2, uvDelay = 8'd1, docDelay = 8'd3, scDelay = 8'd0;
  logic          chgEn, dsgEn, sleepMode, testCurEn;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  battery_protect #(.N_CELLS(N), .DLY_W(DW)) u_battery_protect (
    .clk(clk), .rstN(rstN), .tick(tick),
    .cellOv(cellOv), .cellCe(cellCe), .cellUv(cellUv), .cellUvRel(cellUvRel),
    .docFlag(docFlag), .scFlag(scFlag), .packRecover(packRecover),
    .chargerDet(chargerDet),
    .ovDelay(ovDelay), .uvDelay(uvDelay), .docDelay(docDelay), .scDelay(scDelay),
    .chgEn(chgEn), .dsgEn(dsgEn), .sleepMode(sleepMode), .testCurEn(testCurEn)
  );

  // Vector: {ov, ce, uv, rel, doc, sc, rec, chgr, eChg, eDsg, eSlp, eTc}
  // Each row is one cycle with tick high; outputs checked after that edge.
  localparam logic [11:0] VEC [0:35] = '{
    12'b1000_0000_1100, // 0  R1 ov count 1
    12'b1000_0000_1100, // 1  R1 count 2
    12'b0000_0000_1100, // 2  R10 gap restarts count
    12'b1000_0000_1100, // 3
    12'b1000_0000_1100, // 4
    12'b1000_0000_0100, // 5  R1 trip, R3 dsg stays on
    12'b0000_0000_0100, // 6  R2 still held
    12'b0100_0000_1100, // 7  R2 release
    12'b0101_1000_1100, // 8  R7 doc count
    12'b0101_1000_1100, // 9
    12'b0101_1000_1100, // 10
    12'b0101_1000_1001, // 11 R7 doc trip, R9 probe on
    12'b0101_0000_1001, // 12 R8 held
    12'b0101_0010_1100, // 13 R8 recover
    12'b0101_0100_1001, // 14 R7 sc trip with zero delay
    12'b0101_0010_1100, // 15 R8 recover
    12'b0110_0000_1100, // 16 R4 uv count
    12'b0110_0000_0010, // 17 R4 trip to sleep
    12'b0110_0000_0010, // 18 R5 stays asleep
    12'b0110_0001_1000, // 19 R5 wake, R6 dsg held
    12'b0100_0001_1000, // 20 R6 still held
    12'b0101_0001_1100, // 21 R6 release
    12'b0101_0100_1001, // 22 R9 sc trip
    12'b0110_0100_1001, // 23 uv count
    12'b0110_0100_0010, // 24 R9 uv drops probe for sc
    12'b0110_0010_0010, // 25 sc cleared while asleep
    12'b0101_0001_1000, // 26 R5 wake
    12'b0101_0000_1100, // 27 R6 release
    12'b0101_1000_1100, // 28 doc count
    12'b0101_1000_1100, // 29
    12'b0101_1000_1100, // 30
    12'b0101_1000_1001, // 31 doc trip
    12'b0110_0000_1001, // 32 uv count
    12'b0110_0000_0011, // 33 R9 uv keeps probe for doc
    12'b0101_0011_1000, // 34 wake and recover
    12'b0101_0000_1100  // 35 R6 release
  };

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: {chg,dsg,slp,tc} actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic stepCycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset state", {chgEn, dsgEn, sleepMode, testCurEn}, 4'b1100);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 after release", {chgEn, dsgEn, sleepMode, testCurEn}, 4'b1100);

    for (int i = 0; i < 36; i++) begin
      logic [11:0] v;
      v = VEC[i];
      cellOv      = v[11] ? N'(1 << 3) : '0;
      cellCe      = v[10] ? '1 : '0;
      cellUv      = v[9]  ? N'(1 << 3) : '0;
      cellUvRel   = v[8]  ? '1 : '0;
      docFlag     = v[7];
      scFlag      = v[6];
      packRecover = v[5];
      chargerDet  = v[4];
      tick        = 1'b1;
      stepCycle();
      check($sformatf("vector %0d", i), {chgEn, dsgEn, sleepMode, testCurEn}, v[3:0]);
    end
    tick = 1'b0;
    cellOv = '0; cellCe = '1; cellUv = '0; cellUvRel = '1;
    docFlag = 0; scFlag = 0; packRecover = 0; chargerDet = 0;

    // R1: no counting without tick
    cellOv = N'(1 << (N - 1));
    cellCe = '0;
    repeat (10) stepCycle();
    check("R1 no tick no trip", {chgEn, dsgEn, sleepMode, testCurEn}, 4'b1100);

    // R1: zero delay trips on first tick, top cell
    ovDelay = 8'd0;
    tick = 1'b1;
    stepCycle();
    tick = 1'b0;
    check("R1 zero delay trip", {chgEn, dsgEn, sleepMode, testCurEn}, 4'b0100);

    // R2: one cell above charge-enable keeps charge off
    cellOv = '0;
    cellCe = ~N'(1 << 5);
    repeat (3) stepCycle();
    check("R2 partial release", {chgEn, dsgEn, sleepMode, testCurEn}, 4'b0100);
    cellCe = '1;
    stepCycle();
    check("R2 full release", {chgEn, dsgEn, sleepMode, testCurEn}, 4'b1100);

    // R5: wake while overvoltage is latched keeps charge off
    ovDelay = 8'd0;
    cellOv = N'(1);
    cellCe = '0;
    cellUv = N'(1 << 4);
    cellUvRel = '0;
    tick = 1'b1;
    stepCycle();
    stepCycle();
    tick = 1'b0;
    check("R4 sleep with ov held", {chgEn, dsgEn, sleepMode, testCurEn}, 4'b0010);
    chargerDet = 1'b1;
    stepCycle();
    check("R5 wake with ov latched", {chgEn, dsgEn, sleepMode, testCurEn}, 4'b0000);

    // R10: overcurrent broken just before its trip does not trip
    cellOv = '0; cellCe = '1; cellUv = '0; cellUvRel = '1; chargerDet = 0;
    stepCycle();
    stepCycle();
    check("R6 release after wake", {chgEn, dsgEn, sleepMode, testCurEn}, 4'b1100);
    tick = 1'b1;
    docFlag = 1'b1;
    repeat (3) stepCycle();
    docFlag = 1'b0;
    stepCycle();
    docFlag = 1'b1;
    repeat (3) stepCycle();
    check("R10 doc restart", {chgEn, dsgEn, sleepMode, testCurEn}, 4'b1100);
    stepCycle();
    check("R7 doc trip after restart", {chgEn, dsgEn, sleepMode, testCurEn}, 4'b1001);
    tick = 1'b0;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule